// File: doc/BRIEF.md
# Missing Follow-Pulse Timeout Detector

The block watches two active-low sensors on a production line. A reference sensor fires once for every item that passes. A follow sensor sits a fixed distance downstream and must fire within a set window after each reference event. If it does not, the item is treated as defective and an alarm is raised.

Each input first passes through a two-flop synchroniser and a debounce filter. A reference event then starts a window timer, and a follow event that arrives while the timer runs stops it. If the window runs out first, the error output goes high. It stays high for a fixed hold time, then drops by itself and monitoring resumes.

The window, hold and debounce times are given in microseconds. They are turned into clock cycles from a clock-frequency parameter.

Top module: `follow_pulse_monitor`

## Requirements
- R1: After reset, err_o and err_pulse_o are 0, no window is pending, and with idle (high) inputs no error appears.
- R2: A falling edge (1 to 0) on ref_ni arms the detector. If no follow event comes, err_o rises exactly DEB+WIN+3 cycles after the pin falls. DEB, WIN and HOLD are the debounce, window and hold lengths in cycles.
- R3: Consider a falling edge on fol_ni that comes d cycles after the reference pin edge, with both edges clean. For 1 <= d <= WIN it cancels the pending window, and no error is raised. For d = WIN+1 the error is raised.
- R4: Once raised, err_o stays high for exactly HOLD cycles, then clears by itself. A later missed follow event raises the error again.
- R5: err_pulse_o is high for exactly one cycle, in the first cycle that err_o is high, once per alarm.
- R6: A new reference event while a window is pending restarts the window from that event.
- R7: Only the falling edge of fol_ni counts. A follow event while nothing is pending is ignored. A follow pulse that fell before the reference event and rises inside the window does not cancel it.
- R8: An input level that lasts fewer than DEB cycles is ignored. A bouncing edge counts as one event, taken at the point where the level settles.
- R9: Reference events during the alarm hold are ignored. They neither re-arm the detector nor extend the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_ni | input | 1 | Reference sensor, active low, asynchronous |
| fol_ni | input | 1 | Follow sensor, active low, asynchronous |
| err_o | output | 1 | Missing-follow alarm level, held for HOLD cycles |
| err_pulse_o | output | 1 | One-cycle strobe when the alarm is raised |

## Verification
The bench builds the block with a 2 kHz clock frequency, a 900 ms window, a 1 s hold and a 2 ms debounce. That gives a window of 1800 cycles, a hold of 2000 cycles and a debounce of 4 cycles. With these values every full arm, expiry and hold sequence is only a few thousand cycles long. This lets the bench step the follow offset across the exact window boundary, time the alarm edge to the cycle, and run many random offsets and pulse widths around the window edge. The 4-cycle debounce makes glitches of 2 cycles and short bounce patterns easy to build at the pins.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_ALARM = 2'd2
  } fpm_state_e;

  function automatic int unsigned us_to_cycles(longint unsigned clk_hz, longint unsigned us);
    longint unsigned c;
    c = (clk_hz * us) / 64'd1000000;
    return (c == 0) ? 1 : 32'(c);
  endfunction
endpackage

// File: rtl/fpm_in_cond.sv
module fpm_in_cond #(
  parameter int unsigned DEB_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(DEB_CYC + 1);

  logic [1:0]    sync_q;
  logic          stable_q;
  logic [CW-1:0] cnt_q;
  logic          fall_q;
  logic          s_sync;
  logic          differ;
  logic          flip;

  assign s_sync = sync_q[1];
  assign differ = s_sync != stable_q;
  assign flip   = differ && (cnt_q == CW'(DEB_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 2'b11;
      stable_q <= 1'b1;
      cnt_q    <= '0;
      fall_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_ni};
      fall_q <= flip && !s_sync;
      if (!differ) begin
        cnt_q <= '0;
      end else if (flip) begin
        cnt_q    <= '0;
        stable_q <= s_sync;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fall_o = fall_q;

  // a settled level needs DEB_CYC cycles before it can flip back
  AST_FALL_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |=> !fall_q); // R8
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(DEB_CYC)); // R8
endmodule

// File: rtl/fpm_win_fsm.sv
module fpm_win_fsm
  import fpm_pkg::*;
#(
  parameter int unsigned WIN_CYC  = 1800,
  parameter int unsigned HOLD_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_ev_i,
  input  logic fol_ev_i,
  output logic err_o,
  output logic err_pulse_o
);
  localparam int unsigned MAXC = (WIN_CYC > HOLD_CYC) ? WIN_CYC : HOLD_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  fpm_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic          pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ref_ev_i) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
          end
        end
        ST_ARMED: begin
          if (ref_ev_i) begin
            cnt_q <= '0;  // restart window
          end else if (fol_ev_i) begin
            state_q <= ST_IDLE;
          end else if (cnt_q == CW'(WIN_CYC - 1)) begin
            state_q <= ST_ALARM;
            cnt_q   <= '0;
            err_q   <= 1'b1;
            pulse_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ALARM: begin
          if (cnt_q == CW'(HOLD_CYC - 1)) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign err_o       = err_q;
  assign err_pulse_o = pulse_q;

  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED) |-> (cnt_q < CW'(WIN_CYC))); // R2
  AST_FOL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && fol_ev_i && !ref_ev_i) |=> (state_q == ST_IDLE && !err_o)); // R3
  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ALARM && cnt_q != CW'(HOLD_CYC - 1)) |=> err_o); // R4
  AST_PULSE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> err_pulse_o); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |=> !err_pulse_o); // R5
  AST_ALARM_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ALARM && cnt_q != CW'(HOLD_CYC - 1)) |=> (state_q == ST_ALARM)); // R9
endmodule

// File: rtl/follow_pulse_monitor.sv
module follow_pulse_monitor
  import fpm_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned WINDOW_US   = 900_000,
  parameter int unsigned HOLD_US     = 1_000_000,
  parameter int unsigned DEBOUNCE_US = 2_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_ni,
  input  logic fol_ni,
  output logic err_o,
  output logic err_pulse_o
);
  localparam int unsigned WIN_CYC  = us_to_cycles(64'(CLK_HZ), 64'(WINDOW_US));
  localparam int unsigned HOLD_CYC = us_to_cycles(64'(CLK_HZ), 64'(HOLD_US));
  localparam int unsigned DEB_CYC  = us_to_cycles(64'(CLK_HZ), 64'(DEBOUNCE_US));

  logic [1:0] pin_n;
  logic [1:0] ev;

  assign pin_n = {fol_ni, ref_ni};

  for (genvar g = 0; g < 2; g++) begin : g_in
    fpm_in_cond #(.DEB_CYC(DEB_CYC)) u_cond (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_ni (pin_n[g]),
      .fall_o (ev[g])
    );
  end

  fpm_win_fsm #(.WIN_CYC(WIN_CYC), .HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_ev_i    (ev[0]),
    .fol_ev_i    (ev[1]),
    .err_o       (err_o),
    .err_pulse_o (err_pulse_o)
  );
endmodule

// File: tb/follow_pulse_monitor_tb.sv
`timescale 1ns/1ps
module follow_pulse_monitor_tb;
  localparam int WIN  = 1800;
  localparam int HOLD = 2000;
  localparam int DEB  = 4;
  localparam int RW   = 20;
  localparam int NONE = -100000;
  localparam int LAT  = DEB + WIN + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_n = 1'b1;
  logic fol_n = 1'b1;
  logic err, err_pulse;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int pulse_cnt = 0;
  int hi_cnt = 0;
  int first_pulse = -1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  follow_pulse_monitor #(
    .CLK_HZ(2000), .WINDOW_US(900_000), .HOLD_US(1_000_000), .DEBOUNCE_US(2000)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_ni(ref_n), .fol_ni(fol_n),
    .err_o(err), .err_pulse_o(err_pulse)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (err_pulse) begin
        pulse_cnt++;
        if (first_pulse < 0) first_pulse = cyc;
      end
      if (err) hi_cnt++;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit in_rng(int k, int a, int len);
    return (k >= a) && (k < a + len);
  endfunction

  // rmode: 0 clean, 1 bounce, 2 glitch
  function automatic logic ref_lvl(int k, int r2, int rmode);
    bit low;
    case (rmode)
      1:       low = in_rng(k, 0, 2) || in_rng(k, 4, RW);
      2:       low = in_rng(k, 0, 2);
      default: low = in_rng(k, 0, RW);
    endcase
    if (r2 > NONE && in_rng(k, r2, RW)) low = 1'b1;
    return !low;
  endfunction

  function automatic logic fol_lvl(int k, int f, int fw, bit fb);
    bit low;
    if (f <= NONE) low = 1'b0;
    else if (fb) low = in_rng(k, f, 2) || in_rng(k, f + 4, fw);
    else low = in_rng(k, f, fw);
    return !low;
  endfunction

  task automatic trial(string req, int f, int fw, int r2, int rmode, bit fb,
                       int exp_p, int exp_t);
    int ks, ke, t0;
    ks = (f > NONE && f < 0) ? f : 0;
    ke = RW + 8;
    if (f > NONE && f + fw + 8 > ke) ke = f + fw + 8;
    if (r2 > NONE && r2 + RW + 8 > ke) ke = r2 + RW + 8;
    t0 = 0;
    @(negedge clk);
    pulse_cnt = 0; hi_cnt = 0; first_pulse = -1;
    for (int k = ks; k <= ke; k++) begin
      @(negedge clk);
      if (k == 0) t0 = cyc;
      ref_n = ref_lvl(k, r2, rmode);
      fol_n = fol_lvl(k, f, fw, fb);
    end
    ref_n = 1'b1; fol_n = 1'b1;
    while (cyc < t0 + ke + LAT + HOLD + 400) @(negedge clk);
    chk({req, " pulse count"}, pulse_cnt, exp_p);
    chk({req, " err high cycles"}, hi_cnt, exp_p * HOLD);
    if (exp_t >= 0) chk({req, " raise cycle"}, first_pulse - t0, exp_t);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed, d, fw;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk("R1 err at reset", int'(err), 0);
    chk("R1 pulse at reset", int'(err_pulse), 0);
    rst_n = 1'b1;
    repeat (WIN + 100) @(negedge clk);
    chk("R1 no error when idle", hi_cnt + pulse_cnt, 0);

    trial("R2 missed follow", NONE, 0, NONE, 0, 0, 1, LAT);
    trial("R3 follow at WIN", WIN, 30, NONE, 0, 0, 0, -1);
    trial("R3 follow at WIN+1", WIN + 1, 30, NONE, 0, 0, 1, LAT);
    trial("R3 early follow", 1, 30, NONE, 0, 0, 0, -1);
    trial("R4 second alarm resumes", NONE, 0, NONE, 0, 0, 1, LAT);
    trial("R6 restart no follow", NONE, 0, 1700, 0, 0, 1, 1700 + LAT);
    trial("R6 restart late follow ok", 500 + WIN - 5, 30, 500, 0, 0, 0, -1);
    trial("R7 straddling follow", -100, 150, NONE, 0, 0, 1, LAT);
    trial("R7 follow before ref ignored", -300, 20, NONE, 0, 0, 1, LAT);
    trial("R8 ref glitch", NONE, 0, NONE, 2, 0, 0, -1);
    trial("R8 ref bounce", NONE, 0, NONE, 1, 0, 1, 4 + LAT);
    trial("R8 follow bounce", 100, 30, NONE, 0, 1, 0, -1);
    trial("R9 ref during alarm", NONE, 0, LAT + 500, 0, 0, 1, LAT);

    for (int i = 0; i < 10; i++) begin
      d  = 1 + int'($urandom % (WIN + 300));
      fw = DEB + 2 + int'($urandom % 50);
      trial("R3 random offset", d, fw, NONE, 0, 0, (d > WIN) ? 1 : 0,
            (d > WIN) ? LAT : -1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule